// File: doc/BRIEF.md
# Clicking Leader Sync Detector

This block watches a one-bit tape signal and finds the end of a copy-protected leader. That leader is built from groups of pilot half periods, and a short click closes each group. The click is a pair of fast half periods. The block times every half period in processor T-states, using a counter that advances only on a 3.5 MHz tick enable. It checks that each group holds exactly the number of pilot half periods it expects. It then raises a one-cycle `sync_found` pulse when a slow sync cycle arrives in place of a click. Decoding of the marker and data is left to the next stage.

The expected group lengths come from a parameter table that is walked in order and wraps after its last entry. A mode input replaces the table with one constant group length. Each expected length N is preloaded into a counter as 2^CNT_W − N, and the group is complete when that counter rolls over to zero. Any half period that no rule accepts restarts the hunt, and so does a silence longer than the timeout. The current state and the table position are visible at the ports.

Top module: `click_leader_sync`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 (idle), `grp_idx` is 0 and `sync_found` is 0.
- R2: In idle the state changes only on an input edge. The first edge enters state 1 (pilot) with `grp_idx` = 0. Half periods are measured in ticks, and the timer holds its value in any cycle where `tick` is low.
- R3: In state 1, a half period from PILOT_T·3/4 to PILOT_T·5/4 ticks (1626 to 2710 by default) counts as pilot. Any other half period returns the block to state 0.
- R4: After exactly the expected number of pilot half periods the state becomes 2. The next edge records the first half of a trial cycle and gives state 3.
- R5: In table mode group k expects GRP_LEN[k] pilot half periods (228, 220, 224, 222 by default). Each click moves `grp_idx` up by one, and it wraps from the last entry back to 0.
- R6: In state 3, a cycle whose two halves total less than CLICK_MAX (2000) ticks is a click. The state returns to 1 with the next group loaded.
- R7: In state 3, a cycle is a sync when both of its halves are below the pilot lower bound and its total lies from SYNC_MIN to SYNC_MAX (2400 to 3800) ticks. `sync_found` is then high for exactly one cycle and the state returns to 0.
- R8: A trial cycle that is neither a click nor a sync returns the block to state 0 with no pulse.
- R9: Outside idle, TIMEOUT_T (6000) ticks with no edge return the block to state 0.
- R10: With `fixed_mode` = 1, every group expects FIX_LEN pilot half periods and the table is ignored.
- R11: The input passes through a two-flop synchroniser, and an edge is a change of the synchronised level. A toggle made just after a clock edge moves the state on the third following rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | T-state enable that advances the half-period timer |
| tape_in | input | 1 | Raw tape level |
| fixed_mode | input | 1 | 1: constant group length; 0: table sequence |
| sync_found | output | 1 | One-cycle pulse when the real sync is recognised |
| state_o | output | 2 | 0 idle, 1 pilot, 2 first half of trial cycle, 3 second half |
| grp_idx | output | IDX_W | Current table entry |

## Verification
On every cycle, the assertions check that the sync pulse lasts one cycle, comes only from the trial-cycle state on an edge, and leaves the block idle. They also check the restarts for a rejected pilot and for a timeout, that idle waits for an edge, that the timer freezes when the tick is low, and that the table index steps by one on each click. Only the bench scenarios can show that the exact group counts are enforced, that the table wraps, that extra or missing pilots and in-between cycles are rejected, that fixed mode takes the place of the table, and that the sync is accepted after any complete group.

// File: rtl/cls_pkg.sv
package cls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PILOT = 2'd1,
    ST_CYC1  = 2'd2,
    ST_CYC2  = 2'd3
  } cls_state_e;

  // inclusive range test on a tick count
  function automatic logic in_span(int unsigned v, int unsigned lo, int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // short cycle: both halves together under the limit
  function automatic logic is_click(int unsigned a, int unsigned b, int unsigned lim);
    return (a + b) < lim;
  endfunction

  // slow cycle: each half shorter than a pilot, total inside the sync span
  function automatic logic is_sync(int unsigned a, int unsigned b, int unsigned half_lim,
                                   int unsigned lo, int unsigned hi);
    return (a < half_lim) && (b < half_lim) && in_span(a + b, lo, hi);
  endfunction

endpackage

// File: rtl/cls_edge_sync.sv
module cls_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl_chg
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  // change of the synchronised level
  assign lvl_chg = sh[STAGES-1] ^ sh[STAGES];
endmodule

// File: rtl/cls_half_timer.sv
module cls_half_timer #(
  parameter int unsigned TW        = 14,
  parameter int unsigned TIMEOUT_T = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  output logic [TW-1:0] timer,
  output logic          tmo
);
  localparam logic [TW-1:0] T_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                     timer <= '0;
    else if (clr)                   timer <= '0;
    else if (tick && timer != T_MAX) timer <= timer + 1'b1;
  end

  assign tmo = (32'(timer) >= TIMEOUT_T);
endmodule

// File: rtl/cls_group_table.sv
module cls_group_table #(
  parameter int unsigned IDX_W = 2,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned GRP_LEN [1<<IDX_W] = '{228, 220, 224, 222},
  parameter int unsigned FIX_LEN = 250
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             fixed_mode,
  output logic [CNT_W-1:0] load_val
);
  localparam int unsigned N_ENT   = 1 << IDX_W;
  localparam int unsigned CNT_MOD = 1 << CNT_W;

  // counter start value so that the Nth increment rolls over to zero
  function automatic logic [CNT_W-1:0] preload(int unsigned n);
    return CNT_W'((CNT_MOD - (n % CNT_MOD)) % CNT_MOD);
  endfunction

  logic [CNT_W-1:0] ent [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign ent[g] = preload(GRP_LEN[g]);
  end

  assign load_val = fixed_mode ? preload(FIX_LEN) : ent[idx];
endmodule

// File: rtl/click_leader_sync.sv
module click_leader_sync
  import cls_pkg::*;
#(
  parameter int unsigned PILOT_T   = 2168,
  parameter int unsigned TIMEOUT_T = 6000,
  parameter int unsigned CLICK_MAX = 2000,
  parameter int unsigned SYNC_MIN  = 2400,
  parameter int unsigned SYNC_MAX  = 3800,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned GRP_LEN [1<<IDX_W] = '{228, 220, 224, 222},
  parameter int unsigned FIX_LEN   = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tape_in,
  input  logic             fixed_mode,
  output logic             sync_found,
  output logic [1:0]       state_o,
  output logic [IDX_W-1:0] grp_idx
);
  localparam int unsigned PIL_LO = PILOT_T * 3 / 4;
  localparam int unsigned PIL_HI = PILOT_T * 5 / 4;
  localparam int unsigned TW     = $clog2(TIMEOUT_T + 1) + 1;

  cls_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, load_val;
  logic [IDX_W-1:0] idx_q, idx_d, tbl_idx;
  logic [TW-1:0]    first_q, first_d, timer;
  logic             pulse_q, pulse_d;
  logic             lvl_chg, tmo;
  logic             pilot_ok, click_ok, sync_ok;

  cls_edge_sync #(.STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(tape_in), .lvl_chg(lvl_chg)
  );

  cls_half_timer #(.TW(TW), .TIMEOUT_T(TIMEOUT_T)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(lvl_chg), .timer(timer), .tmo(tmo)
  );

  // entry 0 when starting from idle, next entry after a click
  assign tbl_idx = (state_q == ST_IDLE) ? '0 : idx_q + 1'b1;

  cls_group_table #(.IDX_W(IDX_W), .CNT_W(CNT_W), .GRP_LEN(GRP_LEN), .FIX_LEN(FIX_LEN)) u_tbl (
    .idx(tbl_idx), .fixed_mode(fixed_mode), .load_val(load_val)
  );

  // classification of the half period that ends on this edge
  assign pilot_ok = in_span(32'(timer), PIL_LO, PIL_HI);
  assign click_ok = is_click(32'(first_q), 32'(timer), CLICK_MAX);
  assign sync_ok  = is_sync(32'(first_q), 32'(timer), PIL_LO, SYNC_MIN, SYNC_MAX);
  assign cnt_inc  = cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    first_d = first_q;
    pulse_d = 1'b0;
    if (lvl_chg) begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_PILOT;
          idx_d   = '0;
          cnt_d   = load_val;
        end
        ST_PILOT: begin
          if (!pilot_ok) begin
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_inc;
            if (cnt_inc == '0) state_d = ST_CYC1;
          end
        end
        ST_CYC1: begin
          first_d = timer;
          state_d = ST_CYC2;
        end
        ST_CYC2: begin
          if (click_ok) begin
            state_d = ST_PILOT;
            idx_d   = tbl_idx;
            cnt_d   = load_val;
          end else if (sync_ok) begin
            pulse_d = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end else if (state_q != ST_IDLE && tmo) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      first_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      first_q <= first_d;
      pulse_q <= pulse_d;
    end
  end

  assign sync_found = pulse_q;
  assign state_o    = state_q;
  assign grp_idx    = idx_q;
endmodule

// File: rtl/cls_checker.sv
module cls_checker
  import cls_pkg::*;
#(
  parameter int unsigned IDX_W = 2,
  parameter int unsigned TW    = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             lvl_chg,
  input logic [1:0]       state,
  input logic [IDX_W-1:0] grp_idx,
  input logic             tmo,
  input logic             pilot_ok,
  input logic             sync_found,
  input logic [TW-1:0]    timer
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |=> !sync_found); // R7
  AST_PULSE_AFTER_CYC2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |-> ($past(state) == ST_CYC2) && $past(lvl_chg)); // R7
  AST_PULSE_LANDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |-> state == ST_IDLE); // R7
  AST_TIMEOUT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && tmo && !lvl_chg) |=> state == ST_IDLE); // R9
  AST_IDLE_WAITS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !lvl_chg) |=> state == ST_IDLE); // R2
  AST_ENTRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PILOT && $past(state) == ST_IDLE) |-> grp_idx == '0); // R2
  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !lvl_chg) |=> $stable(timer)); // R2
  AST_BAD_PILOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PILOT && lvl_chg && !pilot_ok) |=> state == ST_IDLE); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PILOT && $past(state) == ST_CYC2) |-> grp_idx == IDX_W'($past(grp_idx) + 1)); // R5
endmodule

bind click_leader_sync cls_checker #(.IDX_W(IDX_W), .TW(TW)) u_cls_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .lvl_chg(lvl_chg), .state(state_q),
  .grp_idx(idx_q), .tmo(tmo), .pilot_ok(pilot_ok), .sync_found(sync_found), .timer(timer)
);

// File: tb/test_click_leader_sync.sv
module test_click_leader_sync;
  localparam int PIL = 2168;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       tape = 1'b0;
  logic       fixed = 1'b0;
  logic       sync_found;
  logic [1:0] state_o;
  logic [1:0] grp_idx;

  int total = 0;
  int bad = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  click_leader_sync #(.GRP_LEN('{2, 3, 1, 2}), .FIX_LEN(3)) i_click_leader_sync (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tape_in(tape), .fixed_mode(fixed),
    .sync_found(sync_found), .state_o(state_o), .grp_idx(grp_idx)
  );

  always @(posedge clk) if (rst_n && sync_found) pulses++;

  task automatic chk(string msg, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", msg, act, exp);
    end
  endtask

  task automatic hp(int n);
    repeat (n) @(negedge clk);
    tape = ~tape;
  endtask

  task automatic start_edge();
    @(negedge clk);
    tape = ~tape;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic pilots(int n);
    for (int i = 0; i < n; i++) hp(PIL);
  endtask

  task automatic click();
    hp(667);
    hp(735);
  endtask

  task automatic sync_cycle();
    hp(1500);
    hp(1500);
  endtask

  task automatic t_reset();
    chk("R1 reset state", state_o, 0);
    chk("R1 reset index", grp_idx, 0);
    chk("R1 reset pulse", sync_found, 0);
  endtask

  task automatic t_table_run();
    int p0;
    p0 = pulses;
    start_edge();
    settle();
    chk("R2 first edge enters pilot", state_o, 1);
    chk("R2 first entry is zero", grp_idx, 0);
    pilots(2);
    settle();
    chk("R4 exact count reaches trial cycle", state_o, 2);
    click();
    settle();
    chk("R6 click returns to pilot", state_o, 1);
    chk("R5 index after first click", grp_idx, 1);
    pilots(3); click();
    pilots(1); click();
    pilots(2); click();
    settle();
    chk("R5 index wraps to zero", grp_idx, 0);
    chk("R6 pilot after fourth click", state_o, 1);
    pilots(2);
    chk("R7 no pulse before sync", pulses - p0, 0);
    sync_cycle();
    settle();
    chk("R7 one sync pulse", pulses - p0, 1);
    chk("R7 idle after sync", state_o, 0);
  endtask

  task automatic t_wrong_counts();
    int p0;
    p0 = pulses;
    start_edge();
    pilots(3);
    settle();
    chk("R4 extra pilot read as first trial half", state_o, 3);
    hp(667);
    settle();
    chk("R8 extra pilot then click restarts", state_o, 0);
    start_edge();
    pilots(1);
    hp(667);
    settle();
    chk("R3 short group click restarts", state_o, 0);
    chk("R8 no pulse on wrong counts", pulses - p0, 0);
  endtask

  task automatic t_edges_and_early_sync();
    int p0;
    p0 = pulses;
    start_edge();
    hp(1700);
    hp(2650);
    settle();
    chk("R3 pilots near window edges accepted", state_o, 2);
    sync_cycle();
    settle();
    chk("R7 sync after first group", pulses - p0, 1);
  endtask

  task automatic t_noise();
    start_edge();
    pilots(1);
    hp(1000);
    settle();
    chk("R3 short half restarts", state_o, 0);
    start_edge();
    hp(2800);
    settle();
    chk("R3 long half restarts", state_o, 0);
  endtask

  task automatic t_mid_cycle();
    int p0;
    p0 = pulses;
    start_edge();
    pilots(2);
    hp(1100);
    hp(1100);
    settle();
    chk("R8 in-between cycle restarts", state_o, 0);
    chk("R8 in-between cycle no pulse", pulses - p0, 0);
  endtask

  task automatic t_sync_and_timeout();
    start_edge();
    @(negedge clk);
    @(negedge clk);
    chk("R11 not yet through synchroniser", state_o, 0);
    @(negedge clk);
    chk("R11 edge seen on third clock", state_o, 1);
    repeat (3) @(negedge clk);
    tick = 1'b0;
    repeat (8000) @(negedge clk);
    chk("R2 timer frozen without tick", state_o, 1);
    tick = 1'b1;
    repeat (5900) @(negedge clk);
    chk("R9 before timeout still pilot", state_o, 1);
    repeat (200) @(negedge clk);
    chk("R9 timeout restarts", state_o, 0);
  endtask

  task automatic t_fixed();
    int p0;
    p0 = pulses;
    fixed = 1'b1;
    start_edge();
    pilots(3);
    settle();
    chk("R10 fixed length group complete", state_o, 2);
    click();
    pilots(3);
    sync_cycle();
    settle();
    chk("R10 fixed mode sync pulse", pulses - p0, 1);
    start_edge();
    pilots(2);
    hp(667);
    settle();
    chk("R10 table length ignored in fixed mode", state_o, 0);
    chk("R10 no extra pulse", pulses - p0, 1);
    fixed = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_table_run();
    t_wrong_counts();
    t_edges_and_early_sync();
    t_noise();
    t_mid_cycle();
    t_sync_and_timeout();
    t_fixed();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule